// File: doc/BRIEF.md
# Dual-Link Clocked Serial to Parallel Bridge

This block connects an 8-bit processor bus to two full-duplex serial links. Each link has a receive pair and a transmit pair, and each pair is a data line with its own bit clock of about 2 MHz. All four bit clocks are unrelated to each other and to the system clock. Every clock line and every bus strobe passes through a two-flop synchronizer into one system clock domain. That clock must run at least eight times faster than the fastest bit clock. Edges are then found by comparing the synchronized level with its delayed copy.

A receive path shifts in one bit at each rising edge of its link clock. After eight bits it pushes the byte into a small FIFO. A transmit path pulls a byte from its own FIFO at the start of each eight-bit slot and changes its data line on the falling edges of the link clock. The processor sees a small SRAM-like register space: two receive data ports, two transmit data ports, a status register and an interrupt enable register. Each channel has a sticky error bit. It records both a byte lost to a full receive FIFO and a transmit slot that found nothing to send. A single interrupt line requests service for whatever the software has enabled.

Top module: `ser_par_bridge`

## Requirements
- R1: After reset the status register reads 0x3C, the interrupt enable register reads 0x00, `irq` is low and both transmit lines are high.
- R2: A receive path samples its data at each rising edge of its link clock, most significant bit first. Every eighth bit completes a byte, which enters that channel's receive FIFO. Reading address 0 (channel 0) or 1 (channel 1) returns the oldest byte, and that byte is removed when the read strobe ends.
- R3: Each receive FIFO holds 4 bytes. A byte that completes while the FIFO is full is discarded and sets that channel's sticky error bit (status bit 6 for channel 0, bit 7 for channel 1). The stored bytes are not changed.
- R4: Writing address 2 (channel 0) or 3 (channel 1) queues a byte for transmit. The first falling link-clock edge after reset starts a slot, and so does every eighth falling edge after that. At the start of a slot the path takes the oldest queued byte and sends it most significant bit first, with the line changing only on falling edges.
- R5: A slot that starts while the transmit FIFO is empty sends eight ones and sets that channel's sticky error bit.
- R6: A write to a transmit address while that FIFO already holds 4 bytes is discarded.
- R7: Status at address 4 reads as follows. Bits [1:0] are receive-not-empty for channels 0 and 1. Bits [3:2] are transmit-not-full. Bits [5:4] are transmit-FIFO-empty (transmit wait). Bits [7:6] are the sticky error bits. Reading status changes nothing.
- R8: Writing a one to status bit 6+c clears error bit c, and writing a zero leaves it. When an error event and the clearing write act in the same cycle, the bit stays set.
- R9: Address 5 is a readable enable register. Bits [1:0] enable the receive-not-empty interrupt per channel and bits [3:2] enable the transmit-not-full interrupt. `irq` is the OR of every enabled condition.
- R10: Reading a receive address whose FIFO is empty returns 0x00 and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_bclk | input | 2 | Receive bit clocks, one per channel |
| rx_bdat | input | 2 | Receive NRZ data, one per channel |
| tx_bclk | input | 2 | Transmit bit clocks supplied by the far end |
| tx_bdat | output | 2 | Transmit NRZ data, one per channel |
| cs_n | input | 1 | Bus chip select, active low |
| oe_n | input | 1 | Bus output enable (read), active low |
| we_n | input | 1 | Bus write enable, active low |
| addr | input | 3 | Register address |
| bus_data | inout | 8 | Shared data bus, driven only while cs_n and oe_n are both low |
| irq | output | 1 | Service request to the processor |

## Verification
The interesting collision is a sticky error event that lands in the same system cycle as a software write that clears that bit. The bench provokes it by releasing the write strobe for the status clear at the same moment it drops the channel 0 transmit clock at a slot boundary with an empty FIFO. Both signals pass through synchronizers of equal depth, so the clear and the underrun act on the same edge. A later status read must still show the bit set, because the set wins. A second clear with no competing event then shows the bit going to zero.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int NUM_LINKS = 2;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] ADR_RX_BASE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_TX_BASE = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_IEN     = 3'd5;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [2:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {3{INIT}};
    else     sr <= {sr[1:0], din};
  end

  assign lvl  = sr[1];
  assign prev = sr[2];
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr, count;
  logic         do_push, do_pop;

  assign count   = wptr - rptr;
  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(wptr)));
endmodule

// File: rtl/rx_lane.sv
module rx_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_rise,
  input  logic         raw_dat,
  output logic         push,
  output logic [W-1:0] byte_out
);
  localparam int CW = $clog2(W);

  logic [1:0]    dsync;
  logic [W-2:0]  sh;
  logic [CW-1:0] cnt;
  logic          dbit;

  assign dbit     = dsync[1];
  assign push     = bit_rise && (cnt == CW'(W-1));
  assign byte_out = {sh, dbit};

  always_ff @(posedge clk) begin
    if (rst) begin
      dsync <= '0;
      sh    <= '0;
      cnt   <= '0;
    end else begin
      dsync <= {dsync[0], raw_dat};
      if (bit_rise) begin
        sh  <= {sh[W-3:0], dbit};
        cnt <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
      end
    end
  end

  assert_byte_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    push |=> (cnt == '0));
endmodule

// File: rtl/tx_lane.sv
module tx_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_fall,
  input  logic         have,
  input  logic [W-1:0] fifo_data,
  output logic         pop,
  output logic         underrun,
  output logic         bdat
);
  localparam int CW = $clog2(W);

  logic [W-2:0]  sh;
  logic [CW-1:0] cnt;
  logic          slot_start;

  assign slot_start = bit_fall && (cnt == '0);
  assign pop        = slot_start && have;
  assign underrun   = slot_start && !have;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      cnt  <= '0;
      bdat <= 1'b1;
    end else if (bit_fall) begin
      cnt <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
      if (cnt == '0) begin
        if (have) begin
          bdat <= fifo_data[W-1];
          sh   <= fifo_data[W-2:0];
        end else begin
          bdat <= 1'b1;
          sh   <= '1;
        end
      end else begin
        bdat <= sh[W-2];
        sh   <= {sh[W-3:0], 1'b1};
      end
    end
  end

  assert_change_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    !bit_fall |=> $stable(bdat));
  assert_idle_ones_R5: assert property (@(posedge clk) disable iff (rst)
    underrun |=> bdat);
endmodule

// File: rtl/ser_par_bridge.sv
module ser_par_bridge
  import bridge_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINKS-1:0] rx_bclk,
  input  logic [NUM_LINKS-1:0] rx_bdat,
  input  logic [NUM_LINKS-1:0] tx_bclk,
  output logic [NUM_LINKS-1:0] tx_bdat,
  input  logic                 cs_n,
  input  logic                 oe_n,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    addr,
  inout  wire  [BYTE_W-1:0]    bus_data,
  output logic                 irq
);
  localparam int NL = NUM_LINKS;

  logic [NL-1:0] rx_empty, rx_full, rx_push, rx_pop, rx_ovr;
  logic [NL-1:0] tx_empty, tx_full, tx_push, tx_pop, tx_und;
  logic [BYTE_W-1:0] rx_wdata [NL];
  logic [BYTE_W-1:0] rx_head  [NL];
  logic [BYTE_W-1:0] tx_head  [NL];

  logic [NL-1:0]   err, err_clr;
  logic [2*NL-1:0] ien;
  logic [BYTE_W-1:0] rd_q, rd_mux, wr_cap, status;
  logic [ADDR_W-1:0] wr_addr_q, rd_addr_q;

  // bus strobes through synchronizers
  logic rd_lvl, rd_prev, wr_lvl, wr_prev, rd_end, wr_end, bus_drive;

  link_sync #(.INIT(1'b0)) u_rd_sync (
    .clk(clk), .rst(rst), .din(!cs_n && !oe_n), .lvl(rd_lvl), .prev(rd_prev));
  link_sync #(.INIT(1'b0)) u_wr_sync (
    .clk(clk), .rst(rst), .din(!cs_n && !we_n), .lvl(wr_lvl), .prev(wr_prev));

  assign rd_end    = !rd_lvl && rd_prev;
  assign wr_end    = !wr_lvl && wr_prev;
  assign bus_drive = !cs_n && !oe_n;
  assign bus_data  = bus_drive ? rd_q : 'z;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cap    <= '0;
      wr_addr_q <= '0;
      rd_addr_q <= '0;
    end else begin
      if (wr_lvl) begin
        wr_cap    <= bus_data;
        wr_addr_q <= addr;
      end
      if (rd_lvl) rd_addr_q <= addr;
    end
  end

  // per-channel datapath
  for (genvar c = 0; c < NL; c++) begin : g_ch
    logic rck_lvl, rck_prev, tck_lvl, tck_prev;

    link_sync #(.INIT(1'b0)) u_rck (
      .clk(clk), .rst(rst), .din(rx_bclk[c]), .lvl(rck_lvl), .prev(rck_prev));
    link_sync #(.INIT(1'b1)) u_tck (
      .clk(clk), .rst(rst), .din(tx_bclk[c]), .lvl(tck_lvl), .prev(tck_prev));

    rx_lane #(.W(BYTE_W)) u_rx (
      .clk(clk), .rst(rst),
      .bit_rise(rck_lvl && !rck_prev),
      .raw_dat(rx_bdat[c]),
      .push(rx_push[c]),
      .byte_out(rx_wdata[c]));

    assign rx_pop[c] = rd_end && (rd_addr_q == ADR_RX_BASE + ADDR_W'(c));
    assign rx_ovr[c] = rx_push[c] && rx_full[c] && !(rx_pop[c] && !rx_empty[c]);

    byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst(rst),
      .push(rx_push[c]), .wdata(rx_wdata[c]),
      .pop(rx_pop[c]), .rdata(rx_head[c]),
      .empty(rx_empty[c]), .full(rx_full[c]));

    assign tx_push[c] = wr_end && (wr_addr_q == ADR_TX_BASE + ADDR_W'(c));

    byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst(rst),
      .push(tx_push[c]), .wdata(wr_cap),
      .pop(tx_pop[c]), .rdata(tx_head[c]),
      .empty(tx_empty[c]), .full(tx_full[c]));

    tx_lane #(.W(BYTE_W)) u_tx (
      .clk(clk), .rst(rst),
      .bit_fall(!tck_lvl && tck_prev),
      .have(!tx_empty[c]),
      .fifo_data(tx_head[c]),
      .pop(tx_pop[c]),
      .underrun(tx_und[c]),
      .bdat(tx_bdat[c]));

    assign err_clr[c] = wr_end && (wr_addr_q == ADR_STAT) && wr_cap[3*NL + c];

    assert_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
      (rx_ovr[c] || tx_und[c]) |=> err[c]);
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (err_clr[c] && !rx_ovr[c] && !tx_und[c]) |=> !err[c]);
  end

  // status, enables, read path, interrupt
  assign status = BYTE_W'({err, tx_empty, ~tx_full, ~rx_empty});

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NL; c++) begin
      if (addr == ADR_RX_BASE + ADDR_W'(c) && !rx_empty[c]) rd_mux = rx_head[c];
    end
    if (addr == ADR_STAT) rd_mux = status;
    if (addr == ADR_IEN)  rd_mux = BYTE_W'(ien);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      err  <= '0;
      ien  <= '0;
      irq  <= 1'b0;
    end else begin
      rd_q <= rd_mux;
      err  <= (err & ~err_clr) | rx_ovr | tx_und;
      if (wr_end && wr_addr_q == ADR_IEN) ien <= wr_cap[2*NL-1:0];
      irq  <= |((~rx_empty & ien[NL-1:0]) | (~tx_full & ien[2*NL-1:NL]));
    end
  end

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq);
endmodule

// File: tb/sim_ser_par_bridge.sv
module sim_ser_par_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rclk = 2'b00, rdat = 2'b00, tclk = 2'b11;
  wire  [1:0] tx_bdat;
  logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [2:0] addr = 3'd0;
  logic       drv = 1'b0;
  logic [7:0] drv_val = 8'h00;
  wire  [7:0] bus_data;
  wire        irq;

  assign bus_data = drv ? drv_val : 8'hzz;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_par_bridge #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .rx_bclk(rclk), .rx_bdat(rdat), .tx_bclk(tclk),
    .tx_bdat(tx_bdat), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .bus_data(bus_data), .irq(irq));

  int n_chk = 0, n_fail = 0;
  logic [7:0] rxm [2][DEPTH];
  int rxn [2];
  int txn [2];
  logic errm [2];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic [7:0] s = '0;
    for (int c = 0; c < 2; c++) begin
      s[c]   = (rxn[c] != 0);
      s[2+c] = (txn[c] < DEPTH);
      s[4+c] = (txn[c] == 0);
      s[6+c] = errm[c];
    end
    return s;
  endfunction

  task automatic m_rx_push(input int ch, input logic [7:0] b);
    if (rxn[ch] < DEPTH) begin rxm[ch][rxn[ch]] = b; rxn[ch]++; end
    else errm[ch] = 1'b1;
  endtask

  function automatic logic [7:0] m_rx_pop(input int ch);
    logic [7:0] v;
    if (rxn[ch] == 0) return 8'h00;
    v = rxm[ch][0];
    for (int i = 0; i < DEPTH-1; i++) rxm[ch][i] = rxm[ch][i+1];
    rxn[ch]--;
    return v;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input int fall_ch);
    @(negedge clk);
    addr = a; drv_val = d; drv = 1'b1; cs_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1; cs_n = 1'b1;
    if (fall_ch >= 0) tclk[fall_ch] = 1'b0;
    repeat (3) @(negedge clk);
    drv = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; cs_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    d = bus_data;
    oe_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_send(input int ch, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      rdat[ch] = b[i]; rclk[ch] = 1'b0;
      repeat (8) @(negedge clk);
      rclk[ch] = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic tx_bit(input int ch, output logic b);
    @(negedge clk);
    tclk[ch] = 1'b0;
    repeat (6) @(negedge clk);
    b = tx_bdat[ch];
    tclk[ch] = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic tx_slot(input int ch, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    logic b;
    for (int i = 7; i >= 0; i--) begin tx_bit(ch, b); got[i] = b; end
    chk(tag, got, exp);
  endtask

  task automatic stat_chk(input string tag);
    logic [7:0] v;
    bus_read(3'd4, v);
    chk(tag, v, exp_status());
  endtask

  initial begin
    for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] v, e;
    logic b;
    for (int c = 0; c < 2; c++) begin rxn[c] = 0; txn[c] = 0; errm[c] = 1'b0; end
    void'($urandom(32'd20091121));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(3'd4, v);  chk("R1 status", v, 8'h3C);
    bus_read(3'd5, v);  chk("R1 ien", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tx idle", {6'd0, tx_bdat}, 8'h03);

    // R10 empty receive read
    bus_read(3'd0, v);  chk("R10 empty read", v, 8'h00);
    stat_chk("R10 status unchanged");

    // R2 receive, both channels
    rx_send(0, 8'hA5); m_rx_push(0, 8'hA5);
    stat_chk("R2 rx0 not empty");
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    bus_read(3'd0, v); chk("R2 rx0 byte", v, m_rx_pop(0));
    stat_chk("R2 rx0 popped");
    rx_send(1, 8'h3C); m_rx_push(1, 8'h3C);
    rx_send(1, 8'hC3); m_rx_push(1, 8'hC3);
    bus_read(3'd1, v); chk("R2 rx1 order a", v, m_rx_pop(1));
    bus_read(3'd1, v); chk("R2 rx1 order b", v, m_rx_pop(1));

    // R3 overrun
    for (int i = 0; i < 5; i++) begin
      rx_send(1, 8'h10 + 8'(i)); m_rx_push(1, 8'h10 + 8'(i));
    end
    stat_chk("R3 overrun flag");
    bus_read(3'd4, v); stat_chk("R7 status read no side effect");
    for (int i = 0; i < 4; i++) begin
      bus_read(3'd1, v); chk("R3 kept bytes", v, m_rx_pop(1));
    end
    bus_read(3'd1, v); chk("R3 fifth lost", v, 8'h00);

    // R8 write-one-to-clear
    bus_write(3'd4, 8'h3F, -1); stat_chk("R8 zero bits keep");
    bus_write(3'd4, 8'h80, -1); errm[1] = 1'b0; stat_chk("R8 clear ch1");

    // R4 transmit
    bus_write(3'd2, 8'h96, -1); txn[0]++;
    stat_chk("R7 tx wait low");
    tx_slot(0, 8'h96, "R4 tx0 byte"); txn[0]--;
    stat_chk("R4 tx0 empty again");

    // R5 underrun
    tx_slot(0, 8'hFF, "R5 idle ones"); errm[0] = 1'b1;
    stat_chk("R5 underrun flag");

    // R6 full transmit fifo
    for (int i = 1; i <= 5; i++) begin
      bus_write(3'd3, 8'(i * 8'h11), -1);
      if (txn[1] < DEPTH) txn[1]++;
    end
    stat_chk("R6 tx1 full");
    for (int i = 1; i <= 4; i++) begin
      tx_slot(1, 8'(i * 8'h11), "R6 tx1 queued"); txn[1]--;
    end
    tx_slot(1, 8'hFF, "R6 fifth dropped"); errm[1] = 1'b1;

    // R8 set wins over clear in the same cycle
    bus_write(3'd4, 8'h40, 0);
    b = tx_bdat[0];
    tclk[0] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 collision slot bit", {7'd0, b}, 8'h01);
    for (int i = 0; i < 7; i++) tx_bit(0, b);
    stat_chk("R8 set wins");
    bus_write(3'd4, 8'hC0, -1); errm[0] = 1'b0; errm[1] = 1'b0;
    stat_chk("R8 clear both");

    // R9 interrupt
    bus_write(3'd5, 8'h01, -1);
    bus_read(3'd5, v); chk("R9 ien readback", v, 8'h01);
    chk("R9 irq idle", {7'd0, irq}, 8'h00);
    rx_send(0, 8'h5A); m_rx_push(0, 8'h5A);
    chk("R9 irq rx", {7'd0, irq}, 8'h01);
    bus_read(3'd0, v); chk("R2 rx0 5A", v, m_rx_pop(0));
    chk("R9 irq cleared", {7'd0, irq}, 8'h00);
    bus_write(3'd5, 8'h08, -1);
    chk("R9 irq tx ready", {7'd0, irq}, 8'h01);
    bus_write(3'd5, 8'h00, -1);
    chk("R9 irq off", {7'd0, irq}, 8'h00);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int ch;
      ch = int'($urandom % 2);
      e = 8'($urandom);
      if ($urandom % 2 == 0) begin
        rx_send(ch, e); m_rx_push(ch, e);
        if ($urandom % 2 == 0) begin
          bus_read(3'(ch), v); chk("R2 random rx", v, m_rx_pop(ch));
        end
      end else begin
        bus_write(3'd2 + 3'(ch), e, -1); txn[ch]++;
        tx_slot(ch, e, "R4 random tx"); txn[ch]--;
      end
    end
    stat_chk("R7 random status");
    for (int c = 0; c < 2; c++)
      while (rxn[c] > 0) begin
        bus_read(3'(c), v); chk("R2 drain", v, m_rx_pop(c));
      end
    stat_chk("R7 final status");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule